// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel together with the decoder for the byte-wide control word that configures it. Software reaches it through two 8-bit ports that share one pair of write and read strobes. A port select input chooses between them: 0 is the data port and 1 is the control port. The counter only advances in cycles where the `tick_en` input is high. In a system that input is a strobe derived from a 1.19318 MHz reference, so the terminal event arrives count × (1/1193180) s after the load completes.

The channel has three operating modes: single-shot terminal count, periodic rate generator and square wave. It drives one output level, `timer_out`. A count value is always loaded as two data writes, low byte first and then high byte. Reads from the data port alternate in the same byte order. A latch command freezes a snapshot of the count, so that software can read both bytes of one value even while the counter keeps running. When a control word asks for a feature the channel does not offer, `cfg_err` pulses for one cycle and the configuration is left unchanged.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, `timer_out` is 0, `cfg_err` is 0, the counter is idle with a value of 0, and both toggles point at the low byte.
- R2: Data-port writes alternate low byte, then high byte. A low-byte write replaces bits 7:0, stops counting and drives `timer_out` low on the next cycle.
- R3: A high-byte write replaces bits 15:8 and stores the full 16-bit value as the reload period. Counting starts only if that value is nonzero. A zero value leaves the count frozen at 0 whatever ticks arrive.
- R4: Mode 0 (terminal count): the count drops by one on each tick. `timer_out` rises on the tick that takes the count from 1 to 0. It then stays high and the count stays at 0 until the channel is reloaded or reprogrammed.
- R5: Mode 2 (rate generator, period P ≥ 2): `timer_out` is high after the load. It goes low on the tick that takes the count from 2 to 1. On the next tick it returns high and the count reloads to P, giving one low tick in every P ticks.
- R6: Mode 3 (square wave): the count drops by two per tick. On a tick that finds the count at 2 or below, `timer_out` inverts and the count reloads to P. Each half period therefore lasts ceil(P/2) ticks, and the output starts high after the load.
- R7: A control byte with bits 5:4 = 00 is a latch command. It copies the current count into a holding register and points the read toggle at the low byte. It is ignored while an earlier snapshot has not yet been read out in full.
- R8: Data-port reads return the low byte, then the high byte. While a snapshot is held, reads return the snapshot, and the snapshot is released after its high byte has been read. Otherwise reads return the live count.
- R9: Control byte layout: bits 7:6 select the channel, bits 5:4 give the access kind (00 latch, 11 low-then-high), bits 3:1 give the mode and bit 0 is BCD. Each of the following pulses `cfg_err` for exactly one cycle, the cycle after the write, and leaves the configuration unchanged: select 11, access 01 or 10, BCD = 1, or a mode other than 0, 2 or 3.
- R10: A control byte whose select names a channel other than this one's `CHAN_ID` (and is not 11) has no effect and raises no error.
- R11: A valid programming control byte sets the mode and stops the counter. It points the write and read toggles at the low byte and drops any snapshot. It sets `timer_out` to 0 for mode 0 and to 1 for modes 2 and 3.
- R12: When a latch command and a tick fall in the same cycle, the snapshot holds the count from before that tick. When a data write and a tick fall in the same cycle, the write wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable strobe, one per time-base period |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; advances the read toggle when the data port is selected |
| port_sel | input | 1 | 0 selects the data port, 1 selects the control port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte (combinational, valid while the data port is selected) |
| timer_out | output | 1 | Channel output level |
| cfg_err | output | 1 | One-cycle pulse after an unsupported control byte |

## Verification
The collision of interest is a latch command arriving in the same clock cycle as a count tick. The bench provokes it by raising the control write and the tick strobe together. It then reads the snapshot back through the data port and checks that it equals the count from before the tick, while the live count read afterwards has already dropped by one. A second collision, a high-byte write together with a tick, is judged by reading back the loaded value with no decrement applied.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [2:0] {
        MODE_TERM   = 3'd0,
        MODE_RATE   = 3'd2,
        MODE_SQUARE = 3'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [1:0] ACC_LATCH    = 2'b00;
    localparam logic [1:0] ACC_LOHI     = 2'b11;

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import itc_pkg::*;
#(
    parameter int unsigned CHAN_ID = 0
) (
    input  logic       valid_i,
    input  logic [7:0] byte_i,
    output logic       do_latch_o,
    output logic       do_prog_o,
    output tmr_mode_e  prog_mode_o,
    output logic       bad_o
);
    localparam logic [1:0] MY_SEL = 2'(CHAN_ID);

    ctrl_word_t cw;
    logic       mode_ok;

    always_comb begin
        cw          = ctrl_word_t'(byte_i);
        mode_ok     = (cw.mode == 3'd0) || (cw.mode == 3'd2) || (cw.mode == 3'd3);
        prog_mode_o = tmr_mode_e'(cw.mode);
        do_latch_o  = 1'b0;
        do_prog_o   = 1'b0;
        bad_o       = 1'b0;
        if (valid_i) begin
            if (cw.sel == SEL_READBACK) begin
                bad_o = 1'b1;
            end else if (cw.sel == MY_SEL) begin
                if (cw.access == ACC_LATCH) begin
                    do_latch_o = 1'b1;
                end else if (cw.access != ACC_LOHI || cw.bcd || !mode_ok) begin
                    bad_o = 1'b1;
                end else begin
                    do_prog_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import itc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  prog_i,
    input  tmr_mode_e             prog_mode_i,
    input  logic                  wr_i,
    input  logic [DATA_W-1:0]     wr_byte_i,
    output logic [2*DATA_W-1:0]   cnt_o,
    output logic                  out_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        tmr_mode_e        mode;
        logic             running;
        logic             out;
        logic             hi_next;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prog_i) begin
            st_d.mode    = prog_mode_i;
            st_d.running = 1'b0;
            st_d.hi_next = 1'b0;
            st_d.out     = (prog_mode_i != MODE_TERM);
        end else if (wr_i) begin
            if (!st_q.hi_next) begin
                st_d.cnt[DATA_W-1:0] = wr_byte_i;
                st_d.running         = 1'b0;
                st_d.out             = 1'b0;
                st_d.hi_next         = 1'b1;
            end else begin
                st_d.cnt[CNT_W-1:DATA_W] = wr_byte_i;
                st_d.period  = {wr_byte_i, st_q.cnt[DATA_W-1:0]};
                st_d.running = ({wr_byte_i, st_q.cnt[DATA_W-1:0]} != '0);
                st_d.out     = (st_q.mode != MODE_TERM);
                st_d.hi_next = 1'b0;
            end
        end else if (tick_i && st_q.running) begin
            unique case (st_q.mode)
                MODE_TERM: begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt     = '0;
                        st_d.out     = 1'b1;
                        st_d.running = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                MODE_RATE: begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt = st_q.period;
                        st_d.out = 1'b1;
                    end else if (st_q.cnt == TWO) begin
                        st_d.cnt = ONE;
                        st_d.out = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                MODE_SQUARE: begin
                    if (st_q.cnt <= TWO) begin
                        st_d.cnt = st_q.period;
                        st_d.out = ~st_q.out;
                    end else begin
                        st_d.cnt = st_q.cnt - TWO;
                    end
                end
                default: st_d.running = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, period: '0, mode: MODE_TERM,
                      running: 1'b0, out: 1'b0, hi_next: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign out_o = st_q.out;

    assert_lo_write_out_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !prog_i && !st_q.hi_next) |=> !out_o);

    assert_idle_count_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && !wr_i && !prog_i) |=> $stable(cnt_o));

    assert_term_out_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TERM && out_o && !wr_i && !prog_i) |=> out_o);

    assert_rate_low_one_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RATE && st_q.running && !out_o && tick_i && !wr_i && !prog_i)
        |=> out_o);

endmodule

// File: rtl/tmr_readout.sv
module tmr_readout #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog_i,
    input  logic                  latch_i,
    input  logic                  rd_i,
    input  logic [2*DATA_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]     rd_byte_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic             pend;
        logic             rd_hi;
    } ro_state_t;

    ro_state_t st_d, st_q;
    logic [CNT_W-1:0] src;

    always_comb begin
        st_d = st_q;
        if (prog_i) begin
            st_d.pend  = 1'b0;
            st_d.rd_hi = 1'b0;
        end else if (latch_i) begin
            if (!st_q.pend) begin
                st_d.snap  = cnt_i;
                st_d.pend  = 1'b1;
                st_d.rd_hi = 1'b0;
            end
        end else if (rd_i) begin
            st_d.rd_hi = ~st_q.rd_hi;
            if (st_q.rd_hi && st_q.pend) begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{snap: '0, pend: 1'b0, rd_hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src       = st_q.pend ? st_q.snap : cnt_i;
        rd_byte_o = st_q.rd_hi ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
    end

    assert_held_snap_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && st_q.pend && !prog_i) |=> $stable(st_q.snap) && st_q.pend);

    assert_snap_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !latch_i && !prog_i && st_q.pend && st_q.rd_hi) |=> !st_q.pend);

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
    import itc_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              timer_out,
    output logic              cfg_err
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic             ctrl_wr, data_wr, data_rd;
    logic             do_latch, do_prog, bad;
    tmr_mode_e        prog_mode;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] rd_byte;
    logic             err_d, err_q;

    always_comb begin
        ctrl_wr = wr_en && port_sel;
        data_wr = wr_en && !port_sel;
        data_rd = rd_en && !port_sel;
    end

    tmr_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .valid_i     (ctrl_wr),
        .byte_i      (wr_data[7:0]),
        .do_latch_o  (do_latch),
        .do_prog_o   (do_prog),
        .prog_mode_o (prog_mode),
        .bad_o       (bad)
    );

    tmr_countdown #(.DATA_W(DATA_W)) u_cd (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_en),
        .prog_i      (do_prog),
        .prog_mode_i (prog_mode),
        .wr_i        (data_wr),
        .wr_byte_i   (wr_data),
        .cnt_o       (cnt),
        .out_o       (timer_out)
    );

    tmr_readout #(.DATA_W(DATA_W)) u_ro (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_i    (do_prog),
        .latch_i   (do_latch),
        .rd_i      (data_rd),
        .cnt_i     (cnt),
        .rd_byte_o (rd_byte)
    );

    always_comb begin
        err_d   = bad;
        rd_data = port_sel ? '0 : rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign cfg_err = err_q;

    assert_decode_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_latch, do_prog, bad}));

    assert_err_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !ctrl_wr) |=> !cfg_err);

    assert_foreign_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[7:6] != 2'(CHAN_ID) && wr_data[7:6] != 2'b11)
        |=> !cfg_err && $stable(timer_out));

endmodule

// File: tb/interval_timer_channel_test.sv
module interval_timer_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       man_tick = 1'b0, auto_on = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       timer_out, cfg_err, tick_en;
    int         div_cnt = 0;
    int         n_pass = 0, n_total = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
    assign tick_en = man_tick | (auto_on && div_cnt == TICK_DIV-1);

    interval_timer_channel uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
        .timer_out(timer_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_total++;
        if (act == exp) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    task automatic wr(input logic p, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; port_sel = p; wr_data = d;
        @(negedge clk); wr_en = 1'b0; port_sel = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); man_tick = 1'b1;
            @(negedge clk); man_tick = 1'b0;
        end
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); port_sel = 1'b0; rd_en = 1'b1; #1 b = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(lo); rd(hi); v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]); wr(1'b0, v[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int          nlist[5];
        int          plist[5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out", timer_out, 0);
        chk("R1 err", cfg_err, 0);
        rd16(v); chk("R1 count", v, 0);

        // R4 terminal count sweep (mode 0 control byte 0x30)
        nlist = '{1, 2, 3, 7, 300};
        foreach (nlist[k]) begin
            wr(1'b1, 8'h30);
            chk("R11 mode0 out low", timer_out, 0);
            load(16'(nlist[k]));
            chk("R4 out low after load", timer_out, 0);
            tick(nlist[k] - 1);
            chk("R4 out before expiry", timer_out, 0);
            rd16(v); chk("R4 count at 1", v, 1);
            tick(1);
            chk("R4 out at expiry", timer_out, 1);
            tick(3);
            chk("R4 out stays high", timer_out, 1);
            rd16(v); chk("R4 count stays 0", v, 0);
        end

        // R3 zero load leaves counter idle
        wr(1'b1, 8'h30); load(16'h0000); tick(5);
        chk("R3 zero load out", timer_out, 0);
        rd16(v); chk("R3 zero load count", v, 0);

        // R2 low byte mid-count stops counter, drives out low
        wr(1'b1, 8'h34);
        chk("R11 mode2 out high", timer_out, 1);
        wr(1'b0, 8'd10);
        chk("R2 lo write out low", timer_out, 0);
        wr(1'b0, 8'd0);
        chk("R3 hi write out high", timer_out, 1);
        tick(3);
        rd16(v); chk("R2 count before restop", v, 7);
        wr(1'b0, 8'h20);
        chk("R2 lo write stops out", timer_out, 0);
        tick(3);
        rd16(v); chk("R2 stopped count", v, 16'h0020);
        wr(1'b0, 8'h00);
        tick(1);
        rd16(v); chk("R3 restart after hi", v, 16'h001F);

        // R5 rate generator sweep
        plist = '{2, 3, 5, 9, 16};
        foreach (plist[k]) begin
            wr(1'b1, 8'h34); load(16'(plist[k]));
            chk("R5 out after load", timer_out, 1);
            for (int t = 1; t <= 2*plist[k]; t++) begin
                tick(1);
                chk("R5 out per tick", timer_out, (t % plist[k]) == plist[k]-1 ? 0 : 1);
            end
        end

        // R6 square wave sweep
        plist = '{1, 2, 4, 5, 8};
        foreach (plist[k]) begin
            int h;
            h = (plist[k] + 1) / 2;
            wr(1'b1, 8'h36); load(16'(plist[k]));
            chk("R6 out after load", timer_out, 1);
            for (int t = 1; t <= 3*plist[k] + 2; t++) begin
                tick(1);
                chk("R6 out per tick", timer_out, ((t / h) % 2) == 0 ? 1 : 0);
            end
        end

        // R7 / R8 latch and read order
        wr(1'b1, 8'h30); load(16'h1234); tick(4);
        wr(1'b1, 8'h00);
        tick(3);
        wr(1'b1, 8'h00);
        rd16(v); chk("R7 held snapshot kept", v, 16'h1230);
        rd16(v); chk("R8 live after release", v, 16'h122D);
        rd(b); chk("R8 live lo", b, 8'h2D);
        wr(1'b1, 8'h00);
        rd(b); chk("R7 toggle reset to lo", b, 8'h2D);
        tick(2);
        rd(b); chk("R8 snapshot hi", b, 8'h12);
        rd(b); chk("R8 released lo live", b, 8'h2B);
        rd(b);

        // R12 latch and tick together
        @(negedge clk); wr_en = 1'b1; port_sel = 1'b1; wr_data = 8'h00; man_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; port_sel = 1'b0; man_tick = 1'b0;
        rd16(v); chk("R12 snapshot is pre-tick", v, 16'h122B);
        rd16(v); chk("R12 live after tick", v, 16'h122A);
        // R12 data write beats tick
        wr(1'b0, 8'h50);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; man_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; man_tick = 1'b0;
        rd16(v); chk("R12 write wins over tick", v, 16'h0050);

        // R9 errors leave config unchanged
        wr(1'b1, 8'h30); load(16'd3);
        begin
            logic [7:0] bad_list[5];
            bad_list = '{8'hC0, 8'h10, 8'h20, 8'h31, 8'h3A};
            foreach (bad_list[k]) begin
                wr(1'b1, bad_list[k]);
                chk("R9 err raised", cfg_err, 1);
                @(negedge clk);
                chk("R9 err one cycle", cfg_err, 0);
            end
        end
        tick(2);
        chk("R9 config kept out", timer_out, 0);
        tick(1);
        chk("R9 config kept expiry", timer_out, 1);
        for (int m = 0; m < 8; m++) begin
            wr(1'b1, 8'h30 | 8'(m << 1));
            chk("R9 mode sweep err", cfg_err, (m == 0 || m == 2 || m == 3) ? 0 : 1);
        end

        // R10 foreign channel ignored
        wr(1'b1, 8'h34); load(16'd6); tick(2);
        wr(1'b1, 8'h70); chk("R10 no err", cfg_err, 0);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'hB6);
        chk("R10 out kept", timer_out, 1);
        rd16(v); chk("R10 count kept, no latch", v, 4);
        tick(3);
        chk("R10 still counting", timer_out, 0);

        // R11 programming stops and resets toggles
        wr(1'b1, 8'h30); load(16'd5); tick(2);
        wr(1'b1, 8'h34);
        chk("R11 prog out", timer_out, 1);
        tick(3);
        rd16(v); chk("R11 counter stopped", v, 3);
        wr(1'b0, 8'd7);
        wr(1'b1, 8'h34);
        load(16'd9);
        rd16(v); chk("R11 write toggle reset", v, 9);

        // R5 with divided time base: period in clocks = P * TICK_DIV
        wr(1'b1, 8'h34); load(16'd5);
        auto_on = 1'b1;
        begin
            logic prev;
            int   n;
            prev = timer_out;
            forever begin
                @(negedge clk);
                if (prev && !timer_out) break;
                prev = timer_out;
            end
            n = 0; prev = 1'b0;
            forever begin
                @(negedge clk); n++;
                if (prev && !timer_out) break;
                prev = timer_out;
            end
            chk("R5 divided period clocks", n, 5 * TICK_DIV);
        end
        auto_on = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule